// File: doc/BRIEF.md
# UART Prescaled Baud Tick Generator

This block makes the 16x oversampling enable for one serial channel. A free-running divide-by-13 prescaler brings the 24 MHz system clock down to about 1.8462 MHz. A 16-bit down counter then divides that rate by a divisor that the host programs. The output is a one-clock tick at sixteen times the chosen baud rate. The transmitter and the receiver of the channel both take their timing from this one tick stream. A second channel uses a second instance.

The host loads the divisor as two bytes, low and high, through a single-cycle write strobe. Every byte write reloads the counter at once with the full new divisor, so a new rate takes effect without waiting for the old count to run out. The usual divisors are 1 for 115200 baud, 12 for 9600, 384 for 300 and 2304 for 50. A divisor of zero is not a supported setting: the block stays idle and makes no ticks while the divisor is zero. A read port returns either divisor byte unchanged.

Top module: `baudgen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears both divisor bytes and the counter to zero. After reset no tick is produced, and rdData reads 0 for both byte selects.
- R2: The prescaler counts every system clock and raises its enable on every 13th clock. The counter moves only on that enable, so every tick comes exactly one clock after a prescaler enable.
- R3: A write (wrEn high at a clock edge) replaces one divisor byte and reloads the counter with the full new 16-bit divisor in the same edge. After a write of divisor D the next tick comes between 4*13+1 and 5*13+2 clocks later for D=5, whatever count was in progress.
- R4: With a steady nonzero divisor D, consecutive ticks are exactly 13*D clocks apart. This holds for D = 2, 12, 384 and 2304.
- R5: With a divisor of 1 a tick follows every prescaler enable, giving a tick period of 13 clocks.
- R6: While the 16-bit divisor is zero no tick is produced and the counter stays at zero. This holds after reset and after zero is written over a running nonzero divisor.
- R7: wrSel=0 selects the low byte (divisor bits 7:0) and wrSel=1 selects the high byte (bits 15:8), for both writes and reads. rdSel picks the byte that rdData shows combinationally, with the byte unchanged.
- R8: Each tick is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Divisor byte write strobe |
| wrSel | input | 1 | Write byte select: 0 low, 1 high |
| wrData | input | 8 | Byte to write |
| rdSel | input | 1 | Read byte select: 0 low, 1 high |
| rdData | output | 8 | Selected divisor byte |
| tick | output | 1 | One-clock enable at 16x baud rate |

## Verification
The assertions check four things on every cycle. They check that a tick lasts one clock and always follows a prescaler enable. They check that the counter holds the divisor right after every write and every tick. They check that the counter stays at zero while the divisor is zero. Only the bench scenarios can show the actual tick periods for each divisor, the rate change after a rewrite in the middle of a count, that ticks stop after zero is written, and the byte lanes of the read port.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  localparam int PRESCALE = 13;
  localparam int BYTE_W   = 8;
  localparam int DIV_W    = 2 * BYTE_W;

  typedef struct packed {
    logic loadLo;   // write low byte and reload counter
    logic loadHi;   // write high byte and reload counter
    logic reload;   // terminal count reached on enable
    logic decr;     // step counter down on enable
  } dpStrobes_t;
endpackage

// File: rtl/baudgen_ctrl.sv
module baudgen_ctrl
  import baudgen_pkg::*;
#(
  parameter int PRE_DIV = PRESCALE
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic       cntIsOne,
  input  logic       cntIsZero,
  output dpStrobes_t strb,
  output logic       preEn,
  output logic       tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign preEn = (preCnt == PRE_LAST);

  always_comb begin
    strb.loadLo = wrEn && !wrSel;
    strb.loadHi = wrEn && wrSel;
    strb.reload = preEn && !wrEn && cntIsOne;
    strb.decr   = preEn && !wrEn && !cntIsOne && !cntIsZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= 1'b0;
    end else begin
      tick <= strb.reload;
    end
  end
endmodule

// File: rtl/baudgen_dp.sv
module baudgen_dp
  import baudgen_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  dpStrobes_t    strb,
  input  logic [BW-1:0] wrData,
  input  logic          rdSel,
  output logic [BW-1:0] rdData,
  output logic          cntIsOne,
  output logic          cntIsZero,
  output logic [2*BW-1:0] divValue,
  output logic [2*BW-1:0] cntValue
);
  localparam int DW = 2 * BW;

  logic [BW-1:0] divLo;
  logic [BW-1:0] divHi;
  logic [DW-1:0] nextDiv;
  logic [DW-1:0] cnt;

  always_comb begin
    nextDiv = {divHi, divLo};
    if (strb.loadLo) nextDiv[BW-1:0]  = wrData;
    if (strb.loadHi) nextDiv[DW-1:BW] = wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divLo <= '0;
      divHi <= '0;
      cnt   <= '0;
    end else begin
      divLo <= nextDiv[BW-1:0];
      divHi <= nextDiv[DW-1:BW];
      if (strb.loadLo || strb.loadHi) begin
        cnt <= nextDiv;
      end else if (strb.reload) begin
        cnt <= {divHi, divLo};
      end else if (strb.decr) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cntIsOne  = (cnt == DW'(1));
  assign cntIsZero = (cnt == '0);
  assign rdData    = rdSel ? divHi : divLo;
  assign divValue  = {divHi, divLo};
  assign cntValue  = cnt;
endmodule

// File: rtl/baudgen.sv
module baudgen
  import baudgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdSel,
  output logic [BYTE_W-1:0] rdData,
  output logic              tick
);
  dpStrobes_t       strb;
  logic             preEn;
  logic             cntIsOne;
  logic             cntIsZero;
  logic [DIV_W-1:0] divValue;
  logic [DIV_W-1:0] cntValue;

  baudgen_ctrl #(.PRE_DIV(PRESCALE)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel),
    .cntIsOne(cntIsOne), .cntIsZero(cntIsZero),
    .strb(strb), .preEn(preEn), .tick(tick)
  );

  baudgen_dp #(.BW(BYTE_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData),
    .cntIsOne(cntIsOne), .cntIsZero(cntIsZero),
    .divValue(divValue), .cntValue(cntValue)
  );
endmodule

// File: rtl/baudgen_chk.sv
module baudgen_chk
  import baudgen_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic             preEn,
  input logic             tick,
  input logic [DIV_W-1:0] divValue,
  input logic [DIV_W-1:0] cntValue
);
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R8

  AST_TICK_AFTER_ENABLE: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(preEn)); // R2

  AST_WRITE_RELOADS: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> (cntValue == divValue)); // R3

  AST_TICK_RELOADS: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cntValue == divValue)); // R4

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (divValue == '0) |-> (cntValue == '0 && !tick)); // R6
endmodule

bind baudgen baudgen_chk u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .preEn(preEn), .tick(tick),
  .divValue(divValue), .cntValue(cntValue)
);

// File: tb/baudgen_test.sv
module baudgen_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       wrEn;
  logic       wrSel;
  logic [7:0] wrData;
  logic       rdSel;
  logic [7:0] rdData;
  logic       tick;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  localparam int NVEC = 5;
  localparam int VEC_DIV [NVEC] = '{1, 2, 12, 384, 2304};
  localparam int VEC_PER [NVEC] = '{13, 26, 156, 4992, 29952};
  localparam string VEC_REQ [NVEC] = '{"R5", "R4", "R4", "R4", "R4"};

  baudgen uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .tick(tick)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeByte(input bit sel, input logic [7:0] val);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeDiv(input int d);
    writeByte(1'b0, d[7:0]);
    writeByte(1'b1, d[15:8]);
  endtask

  // waits on negedges until tick is seen; returns cycles waited or -1
  task automatic waitTick(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (tick) begin n = i; break; end
    end
  endtask

  task automatic countTicks(input int span, output int n);
    n = 0;
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (tick) n++;
    end
  endtask

  initial begin
    int n;
    int wide;
    rst = 1'b1; wrEn = 1'b0; wrSel = 1'b0; wrData = '0; rdSel = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rdSel = 1'b0; #1 check("R1 low byte after reset", rdData, 0);
    rdSel = 1'b1; #1 check("R1 high byte after reset", rdData, 0);
    countTicks(400, n);
    check("R1/R6 no ticks after reset", n, 0);

    // vector table: divisor versus tick period
    for (int v = 0; v < NVEC; v++) begin
      writeDiv(VEC_DIV[v]);
      waitTick(13 * VEC_DIV[v] + 30, n);
      check({VEC_REQ[v], " first tick"}, (n > 0) ? 1 : 0, 1);
      waitTick(13 * VEC_DIV[v] + 30, n);
      check({VEC_REQ[v], " tick period"}, n, VEC_PER[v]);
    end

    // R8 tick width with divisor 1
    writeDiv(1);
    waitTick(40, n);
    @(negedge clk);
    wide = tick;
    check("R8 tick low on following cycle", wide, 0);

    // R7 byte lanes
    writeByte(1'b0, 8'hA5);
    writeByte(1'b1, 8'h3C);
    rdSel = 1'b0; #1 check("R7 low byte readback", rdData, 8'hA5);
    rdSel = 1'b1; #1 check("R7 high byte readback", rdData, 8'h3C);

    // R3 immediate reload mid-count
    writeDiv(5);
    waitTick(100, n);
    repeat (39) @(negedge clk);
    writeByte(1'b0, 8'd5);
    waitTick(200, n);
    n = n + 1;
    check("R3 reload delay in window", (n > 52 && n <= 67) ? 1 : 0, 1);
    if (!(n > 52 && n <= 67)) $display("  R3 measured delay %0d", n);

    // R6 zero over running divisor
    writeDiv(0);
    countTicks(600, n);
    check("R6 no ticks after zero written", n, 0);
    rdSel = 1'b0; #1 check("R6 low byte reads zero", rdData, 0);

    // R1 reset while running
    writeDiv(1);
    waitTick(40, n);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    rdSel = 1'b0; #1 check("R1 reset clears low byte", rdData, 0);
    countTicks(300, n);
    check("R1 no ticks after second reset", n, 0);

    done = 1'b1;
  end

  initial begin
    wait (done || cycles >= 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule